// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block couples two 18-bit tristate buses, side A and side B, through two independent storage paths. Data moves from A to B through one path and from B to A through the other. Each path has its own clock, an active-low clock enable, a latch-enable level and an active-low output enable. While its pass (latch-enable) input is high, a path is transparent and its output follows its input within the same time step. While pass is low, the path is an edge register: it loads on a rising clock edge when the clock enable is asserted, and otherwise keeps its contents.

When pass falls, the path keeps the value that was at its input just before the fall. That value stays until the next enabled rising edge. Each path drives its destination bus only while its output enable is low; otherwise it releases that bus to high impedance. A drive flag output per bus shows whether the block is driving it. Both paths clear to zero through a synchronous active-low reset, which each path samples on its own clock.

The block does not arbitrate between its two drivers. The system around it must never assert both output enables at the same time.

Top module: `ubt_xcvr`

## Requirements
- R1: The data width is a parameter `W`, 18 by default, and both paths carry all `W` bits unchanged, including bit 0 and bit `W-1`.
- R2: While `pass_ab` is high and `oen_ab` is low, `b_io` equals `a_io` with no clock edge needed; the same holds for `pass_ba`, `oen_ba`, from `b_io` to `a_io`.
- R3: While `pass_ab` is low and `cen_ab_n` is low, a rising edge of `clk_ab` loads `a_io` into the A-to-B path, and the loaded value appears on `b_io` after that edge.
- R4: While `cen_ab_n` (or `cen_ba_n`) is high and pass is low, rising clock edges leave the stored value unchanged.
- R5: When pass falls, the path keeps the input value present just before the fall, whatever the input does afterwards, until the next enabled rising edge.
- R6: `b_drv_o` is 1 exactly when `oen_ab` is 0, and `b_io` then carries the stored A-to-B value; with `oen_ab` at 1 the block releases `b_io`, so a value driven externally onto `b_io` reads back unchanged. `a_drv_o` and `a_io` follow `oen_ba` in the same way.
- R7: The B-to-A path loads, holds and passes data under `clk_ba`, `cen_ba_n`, `pass_ba`, `oen_ba` alone, and activity on it leaves the A-to-B stored value unchanged.
- R8: A rising clock edge while `rst_n` is 0 clears that path's stored value to all zeros (with pass low, the driven bus then reads 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled on each path's clock |
| clk_ab | input | 1 | Clock of the A-to-B path |
| clk_ba | input | 1 | Clock of the B-to-A path |
| pass_ab | input | 1 | A-to-B latch enable; high selects transparent mode |
| pass_ba | input | 1 | B-to-A latch enable; high selects transparent mode |
| cen_ab_n | input | 1 | Active-low clock enable of the A-to-B path |
| cen_ba_n | input | 1 | Active-low clock enable of the B-to-A path |
| oen_ab | input | 1 | Active-low output enable onto bus B |
| oen_ba | input | 1 | Active-low output enable onto bus A |
| a_io | inout | W | Bus A: input of A-to-B, output of B-to-A |
| b_io | inout | W | Bus B: input of B-to-A, output of A-to-B |
| a_drv_o | output | 1 | High while the block drives bus A |
| b_drv_o | output | 1 | High while the block drives bus B |

## Verification
Transparent results and drive flags are combinational, so they are due in the same time step as the stimulus. The bench reads them 1 ns after it changes the controls, with no clock edge in between. Loaded and reset values are due after the first rising edge of the path's clock that follows the stimulus. The bench changes its inputs only after a falling edge and reads results 1 ns after the next rising edge. When pass falls, the control changes half a nanosecond before the data does, so the latch closes on the old input and never races the new one.

// File: rtl/ubt_pkg.sv
// Package: shared definitions for the bidirectional latch/register transceiver.
// Assumes: nothing; holds the default width and the path mode encoding.
package ubt_pkg;
    localparam int unsigned UBT_W_DEF = 18;

    // Operating mode of one storage path, decoded from its control levels.
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_PASS    = 2'd2
    } ubt_mode_e;

    // Decode pass level and active-low clock enable into a mode.
    function automatic ubt_mode_e decode_mode(input logic pass, input logic cen_n);
        if (pass)        return MODE_PASS;
        else if (!cen_n) return MODE_CAPTURE;
        else             return MODE_HOLD;
    endfunction
endpackage

// File: rtl/ubt_store.sv
// Module: one storage path. A level latch tracks din while pass is high.
// A flop loads din on an enabled rising edge while pass is low. A flag
// records which of the two holds the newer value.
// Assumes: pass changes away from the rising clock edge; rst_n is synchronous to clk.
module ubt_store #(
    parameter int unsigned W = ubt_pkg::UBT_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass,
    input  logic         cen_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    import ubt_pkg::*;

    ubt_mode_e    mode;
    logic [W-1:0] lat_q;
    logic [W-1:0] ff_q;
    logic         ff_newer;

    // Purpose: decode the control levels into the current mode.
    always_comb mode = decode_mode(pass, cen_n);

    // Purpose: transparent latch that keeps the last value seen while pass was high.
    always_latch begin
        if (pass) lat_q = din;
    end

    // Purpose: edge register, loaded only in capture mode, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ff_q <= '0;
        else if (mode == MODE_CAPTURE) ff_q <= din;
    end

    // Purpose: select flag; pass high makes the latch newer, reset or a capture makes the flop newer.
    always_ff @(posedge clk or posedge pass) begin
        if (pass)                      ff_newer <= 1'b0;
        else if (!rst_n)               ff_newer <= 1'b1;
        else if (mode == MODE_CAPTURE) ff_newer <= 1'b1;
    end

    // Purpose: stored output; live input in pass mode, otherwise the newer copy.
    always_comb begin
        if (pass)          q = din;
        else if (ff_newer) q = ff_q;
        else               q = lat_q;
    end

    // R3: an enabled edge with pass low loads the input.
    assert_edge_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CAPTURE) |=> (pass || q == $past(din)));

    // R4: a disabled edge with pass low keeps the stored value.
    assert_gated_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> (pass || $stable(q)));

    // R8: the first edge after reset sees the cleared value.
    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pass || q == '0));
endmodule

// File: rtl/ubt_drive.sv
// Module: output stage of one path. It turns an active-low enable into a
// drive flag and gates the data that goes to the pad.
// Assumes: the parent places the tristate buffer on the inout bus.
module ubt_drive #(
    parameter int unsigned W = ubt_pkg::UBT_W_DEF
) (
    input  logic         oe_n,
    input  logic [W-1:0] val,
    output logic         drv,
    output logic [W-1:0] dout
);
    // Purpose: drive flag and gated data for the pad.
    always_comb begin
        drv  = !oe_n;
        dout = drv ? val : '0;
    end
endmodule

// File: rtl/ubt_xcvr.sv
// Module: top of the bidirectional transceiver. Two storage paths, each with
// its own output stage, are joined onto two tristate buses.
// Assumes: the system never enables both output stages at once; there is no arbitration.
module ubt_xcvr #(
    parameter int unsigned W = ubt_pkg::UBT_W_DEF
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         pass_ab,
    input  logic         pass_ba,
    input  logic         cen_ab_n,
    input  logic         cen_ba_n,
    input  logic         oen_ab,
    input  logic         oen_ba,
    inout  wire  [W-1:0] a_io,
    inout  wire  [W-1:0] b_io,
    output logic         a_drv_o,
    output logic         b_drv_o
);
    logic [W-1:0] q_ab, q_ba;
    logic [W-1:0] dout_b, dout_a;

    // A-to-B path: reads bus A, feeds the bus B output stage.
    ubt_store #(.W(W)) u_store_ab (
        .clk(clk_ab), .rst_n(rst_n), .pass(pass_ab), .cen_n(cen_ab_n),
        .din(a_io), .q(q_ab)
    );
    ubt_drive #(.W(W)) u_drive_b (
        .oe_n(oen_ab), .val(q_ab), .drv(b_drv_o), .dout(dout_b)
    );

    // B-to-A path: reads bus B, feeds the bus A output stage.
    ubt_store #(.W(W)) u_store_ba (
        .clk(clk_ba), .rst_n(rst_n), .pass(pass_ba), .cen_n(cen_ba_n),
        .din(b_io), .q(q_ba)
    );
    ubt_drive #(.W(W)) u_drive_a (
        .oe_n(oen_ba), .val(q_ba), .drv(a_drv_o), .dout(dout_a)
    );

    // Purpose: tristate pads; release the bus whenever its stage is off.
    assign b_io = b_drv_o ? dout_b : 'z;
    assign a_io = a_drv_o ? dout_a : 'z;

    // R6: both stages must never drive at the same time.
    assert_one_driver_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        !(a_drv_o && b_drv_o));

    // R2: an open A-to-B path shows bus A on bus B.
    assert_pass_through_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (pass_ab && !oen_ab && oen_ba) |-> (b_io == a_io));
endmodule

// File: tb/tb_ubt_xcvr.sv
`timescale 1ns/100ps
// Bench: a vector table for the A-to-B path, then directed tests for reset,
// output enable, the B-to-A path, width and reset in mid-operation.
module tb_ubt_xcvr;
    localparam int W = 18;
    localparam int NV = 9;

    // Vector fields: {pass, cen_n, a value, expected b after the edge}
    localparam logic [2*W+1:0] VEC [NV] = '{
        {1'b0, 1'b1, 18'h12345, 18'h00000},   // R4 gated edge after reset
        {1'b0, 1'b0, 18'h12345, 18'h12345},   // R3 enabled load
        {1'b0, 1'b1, 18'h3FFFF, 18'h12345},   // R4 edge ignored
        {1'b1, 1'b1, 18'h2AAAA, 18'h2AAAA},   // R2 transparent
        {1'b1, 1'b0, 18'h15555, 18'h15555},   // R2 transparent wins over clock
        {1'b0, 1'b1, 18'h00F0F, 18'h15555},   // R5 value kept after fall
        {1'b0, 1'b1, 18'h0FFFF, 18'h15555},   // R5 still kept
        {1'b0, 1'b0, 18'h3C3C3, 18'h3C3C3},   // R3 next enabled edge
        {1'b0, 1'b0, 18'h00001, 18'h00001}    // R3 low bit
    };

    logic clk = 1'b0;
    logic rst_n;
    logic pass_ab, pass_ba, cen_ab_n, cen_ba_n, oen_ab, oen_ba;
    logic [W-1:0] tb_a, tb_b;
    logic tb_a_en, tb_b_en;
    wire  [W-1:0] a_io, b_io;
    logic a_drv_o, b_drv_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    assign a_io = tb_a_en ? tb_a : 'z;
    assign b_io = tb_b_en ? tb_b : 'z;

    always #2 clk = ~clk;

    ubt_xcvr #(.W(W)) dut (
        .rst_n(rst_n), .clk_ab(clk), .clk_ba(clk),
        .pass_ab(pass_ab), .pass_ba(pass_ba),
        .cen_ab_n(cen_ab_n), .cen_ba_n(cen_ba_n),
        .oen_ab(oen_ab), .oen_ba(oen_ba),
        .a_io(a_io), .b_io(b_io),
        .a_drv_o(a_drv_o), .b_drv_o(b_drv_o)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0; pass_ab = 1'b0; pass_ba = 1'b0;
        cen_ab_n = 1'b1; cen_ba_n = 1'b1; oen_ab = 1'b1; oen_ba = 1'b1;
        tb_a = '0; tb_a_en = 1'b1; tb_b = '0; tb_b_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); oen_ab = 1'b0;
        after_edge();
        check("R8 reset value on b", b_io, 18'h00000);
        check("R6 drive flag under reset", {17'd0, b_drv_o}, 18'h00001);
        @(negedge clk); rst_n = 1'b1;

        // Vector table for the A-to-B path.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            pass_ab  = VEC[i][2*W+1];
            cen_ab_n = VEC[i][2*W];
            #0.5;
            tb_a = VEC[i][2*W-1:W];
            after_edge();
            check($sformatf("vector %0d (R2/R3/R4/R5)", i), b_io, VEC[i][W-1:0]);
        end

        // R6: release and drive of bus B.
        @(negedge clk); cen_ab_n = 1'b1; oen_ab = 1'b1;
        #1;
        check("R6 b released flag", {17'd0, b_drv_o}, 18'h00000);
        tb_b_en = 1'b1; tb_b = 18'h0ABCD;
        #1;
        check("R6 external value on released b", b_io, 18'h0ABCD);
        @(negedge clk); cen_ab_n = 1'b0; tb_a = 18'h11111;
        after_edge();
        @(negedge clk); cen_ab_n = 1'b1; tb_b_en = 1'b0; oen_ab = 1'b0;
        #1;
        check("R6 b drives stored value", b_io, 18'h11111);

        // R7: B-to-A path on its own controls.
        @(negedge clk); oen_ab = 1'b1; tb_a_en = 1'b0;
        tb_b_en = 1'b1; tb_b = 18'h2468A; cen_ba_n = 1'b0; oen_ba = 1'b0;
        after_edge();
        check("R7 b-to-a load", a_io, 18'h2468A);
        check("R6 a drive flag", {17'd0, a_drv_o}, 18'h00001);
        @(negedge clk); cen_ba_n = 1'b1; tb_b = 18'h13579;
        after_edge();
        check("R4 b-to-a gated edge", a_io, 18'h2468A);
        @(negedge clk); pass_ba = 1'b1;
        #1;
        check("R2 b-to-a transparent", a_io, 18'h13579);
        @(negedge clk); pass_ba = 1'b0; #0.5; tb_b = 18'h00777;
        after_edge();
        check("R5 b-to-a kept after fall", a_io, 18'h13579);
        @(negedge clk); oen_ba = 1'b1; tb_b_en = 1'b0;
        #1; tb_a_en = 1'b1; tb_a = 18'h0; oen_ab = 1'b0;
        #1;
        check("R7 a-to-b value untouched", b_io, 18'h11111);

        // R1: full width, both end bits.
        @(negedge clk); cen_ab_n = 1'b0; tb_a = 18'h20001;
        after_edge();
        check("R1 end bits", b_io, 18'h20001);
        check("R1 width", 18'($bits(a_io)), 18'd18);

        // R8: reset in mid-operation.
        @(negedge clk); cen_ab_n = 1'b1; rst_n = 1'b0;
        after_edge();
        check("R8 mid-run clear", b_io, 18'h00000);
        @(negedge clk); rst_n = 1'b1;
        after_edge();
        check("R8 stays clear after release", b_io, 18'h00000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule